// File: doc/BRIEF.md
# Two-Level ALU Decoder and Arithmetic Unit

This block is the arithmetic stage of a multicycle processor datapath. It takes a 2-bit operation class from the main controller and the 6-bit function field of the current instruction. From these it selects a 4-bit operation code. The block then applies that operation to two 32-bit operands and returns a 32-bit result and a zero flag. It holds no state, so the outputs follow the inputs within the same cycle.

The operation class chooses the decode level:

- Class `00` forces an add, which is used for address arithmetic.
- Class `01` forces a subtract, which is used for branch comparison through the zero flag.
- Class `10` hands the choice to the function field.

Any function value that is not recognised, and the unused class `11`, fall back to add. This keeps the output defined for every input.

Top module: `alu_decode_exec`

## Requirements
- R1: With alu_op = 00 the operation code is 0110 (add), whatever the funct value.
- R2: With alu_op = 01 the operation code is 1110 (subtract), whatever the funct value.
- R3: With alu_op = 10 the funct field maps as follows: 101010 to 1111 (set-less-than), 100111 to 0011 (nor), 100110 to 0010 (xor), 100101 to 0001 (or), 100100 to 0000 (and), 100010 to 1110 (subtract) and 100000 to 0110 (add).
- R4: With alu_op = 10 and any other funct, or with alu_op = 11, the operation code is 0110 (add).
- R5: Code 0110 gives opnd_a + opnd_b modulo 2^32, with no overflow indication.
- R6: Code 1110 gives opnd_a - opnd_b modulo 2^32.
- R7: Codes 0000, 0001, 0010 and 0011 give the bitwise and, or, xor and nor of the operands.
- R8: Code 1111 compares the operands as signed two's-complement values. It returns 1 in bit 0 when opnd_a < opnd_b, otherwise 0, and bits 31..1 are always 0.
- R9: zero is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_ctl | output | 4 | Decoded operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench sweeps all 256 combinations of class and function field. This catches a decoder that lets the function field leak into the fixed add and subtract classes, or one that leaves unrecognised codes undefined instead of falling back to add.

Directed vectors target further corner cases:

- Wrap-around of add and subtract. A design that saturated, or carried into a 33rd bit, would return the wrong result and zero flag.
- Set-less-than with the most negative operand against the most positive, and minus one against one. An unsigned comparison gives the opposite answer in both cases.
- Results that cancel to zero through subtract, xor and nor. This checks that the zero flag reflects the full result rather than only part of it.

// File: rtl/alu_decode_exec.sv
module alu_decode_exec #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       alu_op,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [3:0]       alu_ctl,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  localparam logic [3:0] OP_ADD = 4'b0110;
  localparam logic [3:0] OP_SUB = 4'b1110;
  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_XOR = 4'b0010;
  localparam logic [3:0] OP_NOR = 4'b0011;
  localparam logic [3:0] OP_SLT = 4'b1111;

  logic [3:0] fn_ctl;

  always_comb begin
    case (funct)
      6'b100000: fn_ctl = OP_ADD;
      6'b100010: fn_ctl = OP_SUB;
      6'b100100: fn_ctl = OP_AND;
      6'b100101: fn_ctl = OP_OR;
      6'b100110: fn_ctl = OP_XOR;
      6'b100111: fn_ctl = OP_NOR;
      6'b101010: fn_ctl = OP_SLT;
      default:   fn_ctl = OP_ADD;
    endcase
  end

  always_comb begin
    case (alu_op)
      2'b01:   alu_ctl = OP_SUB;
      2'b10:   alu_ctl = fn_ctl;
      default: alu_ctl = OP_ADD;
    endcase
  end

  logic [WIDTH-1:0] sum, diff;
  logic             lt;

  assign sum  = opnd_a + opnd_b;
  assign diff = opnd_a - opnd_b;
  assign lt   = $signed(opnd_a) < $signed(opnd_b);

  always_comb begin
    case (alu_ctl)
      OP_SUB:  result = diff;
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_NOR:  result = ~(opnd_a | opnd_b);
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt};
      default: result = sum;
    endcase
  end

  assign zero = ~|result;

endmodule

module alu_decode_exec_chk #(
  parameter int WIDTH = 32
) (
  input logic [1:0]       alu_op,
  input logic [5:0]       funct,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [3:0]       alu_ctl,
  input logic [WIDTH-1:0] result,
  input logic             zero
);

  logic [5:0] unused_fn;
  assign unused_fn = funct;

  always_comb begin
    if (alu_op == 2'b00)
      p_fixed_add_r1: assert (alu_ctl == 4'b0110) else $error("p_fixed_add_r1");
    if (alu_op == 2'b01)
      p_fixed_sub_r2: assert (alu_ctl == 4'b1110) else $error("p_fixed_sub_r2");
    if (alu_op == 2'b11)
      p_spare_class_r4: assert (alu_ctl == 4'b0110) else $error("p_spare_class_r4");
    if (alu_ctl == 4'b1111)
      p_slt_upper_clear_r8: assert (result[WIDTH-1:1] == '0) else $error("p_slt_upper_clear_r8");
    if (alu_ctl == 4'b1110 && opnd_a == opnd_b)
      p_equal_sub_zero_r9: assert (zero) else $error("p_equal_sub_zero_r9");
    if (alu_ctl == 4'b0010 && opnd_a != opnd_b)
      p_xor_differs_nonzero_r9: assert (!zero) else $error("p_xor_differs_nonzero_r9");
  end

endmodule

bind alu_decode_exec alu_decode_exec_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_decode_exec_bench.sv
module alu_decode_exec_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]  alu_op;
  logic [5:0]  funct;
  logic [31:0] opnd_a, opnd_b;
  logic [3:0]  alu_ctl;
  logic [31:0] result;
  logic        zero;

  alu_decode_exec u_alu_decode_exec (
    .alu_op(alu_op), .funct(funct), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_ctl(alu_ctl), .result(result), .zero(zero)
  );

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  op;
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        z;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 2'b00, 6'b000000, 32'd5,         32'd3,         32'd8,         1'b0}, // R5
    '{4'd5, 2'b00, 6'b100010, 32'hFFFFFFFF,  32'd1,         32'd0,         1'b1}, // R5 R1 wrap
    '{4'd6, 2'b01, 6'b100000, 32'd7,         32'd7,         32'd0,         1'b1}, // R6 R2
    '{4'd6, 2'b01, 6'b000000, 32'd0,         32'd1,         32'hFFFFFFFF,  1'b0}, // R6 wrap
    '{4'd7, 2'b10, 6'b100100, 32'hF0F0F0F0,  32'hFF00FF00,  32'hF000F000,  1'b0}, // R7 and
    '{4'd7, 2'b10, 6'b100101, 32'hF0F0F0F0,  32'h0F0F0F0F,  32'hFFFFFFFF,  1'b0}, // R7 or
    '{4'd7, 2'b10, 6'b100110, 32'hAAAA5555,  32'hAAAA5555,  32'd0,         1'b1}, // R7 xor
    '{4'd7, 2'b10, 6'b100111, 32'd0,         32'd0,         32'hFFFFFFFF,  1'b0}, // R7 nor
    '{4'd9, 2'b10, 6'b100111, 32'hFFFF0000,  32'h0000FFFF,  32'd0,         1'b1}, // R9 nor to zero
    '{4'd8, 2'b10, 6'b101010, 32'hFFFFFFFF,  32'd1,         32'd1,         1'b0}, // R8 -1 < 1
    '{4'd8, 2'b10, 6'b101010, 32'd1,         32'hFFFFFFFF,  32'd0,         1'b1}, // R8 1 !< -1
    '{4'd8, 2'b10, 6'b101010, 32'h80000000,  32'h7FFFFFFF,  32'd1,         1'b0}, // R8 extremes
    '{4'd8, 2'b10, 6'b101010, 32'd5,         32'd5,         32'd0,         1'b1}, // R8 equal
    '{4'd4, 2'b10, 6'b111111, 32'd2,         32'd3,         32'd5,         1'b0}, // R4 unknown funct
    '{4'd4, 2'b11, 6'b100010, 32'd2,         32'd3,         32'd5,         1'b0}, // R4 spare class
    '{4'd3, 2'b10, 6'b100010, 32'd3,         32'd5,         32'hFFFFFFFE,  1'b0}  // R3 sub via funct
  };

  function automatic logic [3:0] model_ctl(logic [1:0] op, logic [5:0] fn);
    if (op == 2'b00) return 4'b0110;
    if (op == 2'b01) return 4'b1110;
    if (op == 2'b11) return 4'b0110;
    if (fn == 6'b100000) return 4'b0110;
    if (fn == 6'b100010) return 4'b1110;
    if (fn == 6'b100100) return 4'b0000;
    if (fn == 6'b100101) return 4'b0001;
    if (fn == 6'b100110) return 4'b0010;
    if (fn == 6'b100111) return 4'b0011;
    if (fn == 6'b101010) return 4'b1111;
    return 4'b0110;
  endfunction

  function automatic logic [31:0] model_res(logic [3:0] c, logic [31:0] a, logic [31:0] b);
    logic [32:0] wide;
    if (c == 4'b1110) begin wide = {1'b0, a} + {1'b0, ~b} + 33'd1; return wide[31:0]; end
    if (c == 4'b0000) return a & b;
    if (c == 4'b0001) return a | b;
    if (c == 4'b0010) return a ^ b;
    if (c == 4'b0011) return ~(a | b);
    if (c == 4'b1111) begin
      if (a[31] != b[31]) return {31'd0, a[31]};
      return {31'd0, a < b};
    end
    wide = {1'b0, a} + {1'b0, b};
    return wide[31:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    alu_op = op; funct = fn; opnd_a = a; opnd_b = b;
    #1;
  endtask

  logic done = 1'b0;

  initial begin
    alu_op = 2'b00; funct = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset ctl", {28'd0, alu_ctl}, 32'h6);
    check("R5 reset result", result, 32'd0);
    check("R9 reset zero", {31'd0, zero}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].fn, VECS[i].a, VECS[i].b);
      check($sformatf("R%0d vec%0d result", VECS[i].req, i), result, VECS[i].res);
      check($sformatf("R9 vec%0d zero", i), {31'd0, zero}, {31'd0, VECS[i].z});
    end

    for (int op = 0; op < 4; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        logic [31:0] a, b;
        logic [3:0]  ec;
        logic [31:0] er;
        a  = 32'h9E3779B9 * (fn + 1) + op;
        b  = (fn[0]) ? a : 32'h7F4A7C15 ^ (fn << 9);
        ec = model_ctl(op[1:0], fn[5:0]);
        er = model_res(ec, a, b);
        apply(op[1:0], fn[5:0], a, b);
        check($sformatf("R1 R2 R3 R4 sweep op=%0d fn=%0d ctl", op, fn), {28'd0, alu_ctl}, {28'd0, ec});
        check($sformatf("R5 R6 R7 R8 sweep op=%0d fn=%0d result", op, fn), result, er);
        check("R9 sweep zero", {31'd0, zero}, {31'd0, er == 32'd0});
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule